// File: doc/BRIEF.md
# Dual-Plane Blinking Display Scanner

This block time-multiplexes a common-cathode style 7-segment LED display of up to eight digits. A host loads segment patterns into two complete banks of digit memory (plane 0 and plane 1) and a handful of control registers through a small parallel write port. The port has an address bus, a data bus and a chip-select strobe, and each write is committed on the rising edge of the strobe. A free-running multiplex tick, sampled in the block's clock domain, steps a digit scanner across digits 0 through a programmable upper limit. The scanner drives one digit-select line at a time and places that digit's segment pattern on the segment outputs.

Blinking needs no host involvement once it is configured. A prescaler on the multiplex tick produces a blink phase, and each phase picks one of the two planes to feed the scanner. Any segment whose bit differs between the planes therefore flashes. With blinking off, only plane 0 is shown. A display-test mode lights every segment of every scanned digit. A global clear, issued through the configuration register, zeroes both planes at once.

Top module: `blink_scan`

## Requirements
- R1: A register write takes effect only on the first clock in which `wr_cs` is seen high after being low, using `wr_addr`/`wr_data` of that clock; changing address or data while `wr_cs` stays high has no effect.
- R2: A write to address 0x03 sets the scan limit from data bits [2:0]; the scanner covers digits 0 through that value (0 to 7). The value after reset is 7.
- R3: Exactly one `dig_sel` bit is high at all times (bit i = digit i). The digit index moves only on a clock in which `mux_tick` is high, and after the limit digit it returns to 0. A new scan limit is applied at the next digit change.
- R4: Every digit change is followed by exactly one multiplex tick in which `seg_out` is all zeros, before the new digit's pattern is shown.
- R5: A write to address 0x07 with data bit 0 = 1 enables display test and bit 0 = 0 disables it; the other bits are ignored. In test mode every non-blanked scan slot drives `seg_out` all ones.
- R6: A write to address 0x04 with data bit 5 = 1 clears every digit of both planes in the same write. With bit 5 = 0 the digit data is left unchanged.
- R7: Data bit 3 of address 0x04 is the blink enable. When it is 0, only plane 0 contents appear on `seg_out`.
- R8: With blink enabled, the plane shown alternates each blink phase. A phase lasts 4096 multiplex ticks when data bit 2 of address 0x04 is 1 (fast) and 8192 ticks when it is 0 (slow). A new plane choice is applied at the next digit change.
- R9: Whenever a configuration write changes the blink enable bit, the blink prescaler restarts from zero with plane 0 as the current phase.
- R10: Digit d of plane 0 is written at address 0x60+d and digit d of plane 1 at address 0x68+d, with the 8-bit segment pattern in the data (bit i drives `seg_out[i]`).
- R11: After reset both planes are zero, test and blink are off, the slow rate is selected, digit 0 is selected and `seg_out` is all zeros.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mux_tick | input | 1 | Multiplex tick, one clock wide per step |
| wr_cs | input | 1 | Write strobe; commit on rising edge |
| wr_addr | input | 8 | Register address |
| wr_data | input | 8 | Register data |
| dig_sel | output | 8 | One-hot digit select, active high |
| seg_out | output | 8 | Segment drive for the selected digit, active high |

## Verification
The bench aims at scan-limit changes made while the scanner is past the new limit. A design that compares for equality instead of "at or above" would run past the limit and show stale digits. It checks that a held strobe with changing address and data produces no second write; a level-sensitive port would turn test mode on. It times blink phases at both rates and with sparse ticks, and toggles the enable mid-phase. A prescaler that does not restart would flip planes early. Test mode, global clear and the blank slot at each digit change are compared every clock against a behavioural model. A missing blank slot or a one-plane clear shows up as a mismatch on `seg_out`.

// File: rtl/blink_scan.sv
module blink_scan #(
  parameter int DIGITS    = 8,
  parameter int SEG_W     = 8,
  parameter int FAST_LOG2 = 12,
  parameter int SLOW_LOG2 = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mux_tick,
  input  logic              wr_cs,
  input  logic [7:0]        wr_addr,
  input  logic [7:0]        wr_data,
  output logic [DIGITS-1:0] dig_sel,
  output logic [SEG_W-1:0]  seg_out
);
  localparam int IDX_W = $clog2(DIGITS);
  localparam int FAST_LAST = 2**FAST_LOG2 - 1;
  localparam int SLOW_LAST = 2**SLOW_LOG2 - 1;
  localparam logic [7:0] ADR_LIMIT = 8'h03;
  localparam logic [7:0] ADR_CFG   = 8'h04;
  localparam logic [7:0] ADR_TEST  = 8'h07;
  localparam logic [4:0] ADR_P0    = 5'b01100;
  localparam logic [4:0] ADR_P1    = 5'b01101;

  logic [SEG_W-1:0] p0 [DIGITS];
  logic [SEG_W-1:0] p1 [DIGITS];
  logic cs_q, blink_en, fast_rate, test_on, phase, blank, plane_sel;
  logic [IDX_W-1:0] limit, dig;
  logic [SLOW_LOG2-1:0] pre;

  wire wr_fire = wr_cs & ~cs_q;
  wire cfg_wr  = wr_fire && (wr_addr == ADR_CFG);
  wire en_chg  = cfg_wr && (wr_data[3] != blink_en);
  wire [2:0] wr_idx = wr_addr[2:0];
  wire idx_ok  = 32'(wr_idx) < DIGITS;
  wire pre_end = fast_rate ? (pre >= SLOW_LOG2'(FAST_LAST)) : (pre >= SLOW_LOG2'(SLOW_LAST));
  wire [IDX_W-1:0] dig_nxt = (dig >= limit) ? '0 : dig + 1'b1;

  always_ff @(posedge clk) begin
    if (!rst_n) cs_q <= 1'b0;
    else        cs_q <= wr_cs;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      blink_en  <= 1'b0;
      fast_rate <= 1'b0;
      test_on   <= 1'b0;
      limit     <= IDX_W'(DIGITS - 1);
    end else if (wr_fire) begin
      if (wr_addr == ADR_LIMIT) limit <= wr_data[IDX_W-1:0];
      if (wr_addr == ADR_TEST)  test_on <= wr_data[0];
      if (cfg_wr) begin
        blink_en  <= wr_data[3];
        fast_rate <= wr_data[2];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DIGITS; i++) begin
        p0[i] <= '0;
        p1[i] <= '0;
      end
    end else if (wr_fire) begin
      if (cfg_wr && wr_data[5]) begin
        for (int i = 0; i < DIGITS; i++) begin
          p0[i] <= '0;
          p1[i] <= '0;
        end
      end else if (idx_ok && wr_addr[7:3] == ADR_P0) begin
        p0[wr_idx[IDX_W-1:0]] <= wr_data[SEG_W-1:0];
      end else if (idx_ok && wr_addr[7:3] == ADR_P1) begin
        p1[wr_idx[IDX_W-1:0]] <= wr_data[SEG_W-1:0];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || en_chg || !blink_en) begin
      pre   <= '0;
      phase <= 1'b0;
    end else if (mux_tick) begin
      if (pre_end) begin
        pre   <= '0;
        phase <= ~phase;
      end else begin
        pre <= pre + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dig       <= '0;
      blank     <= 1'b1;
      plane_sel <= 1'b0;
    end else if (mux_tick) begin
      if (blank) begin
        blank <= 1'b0;
      end else begin
        blank     <= 1'b1;
        dig       <= dig_nxt;
        plane_sel <= blink_en & phase;
      end
    end
  end

  assign dig_sel = DIGITS'(1) << dig;
  assign seg_out = blank ? '0 : test_on ? '1 : (plane_sel ? p1[dig] : p0[dig]);
endmodule

module blink_scan_chk #(
  parameter int DIGITS = 8,
  parameter int SEG_W  = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              mux_tick,
  input logic              wr_cs,
  input logic              cs_q,
  input logic [7:0]        wr_addr,
  input logic [7:0]        wr_data,
  input logic              test_on,
  input logic [DIGITS-1:0] dig_sel,
  input logic [SEG_W-1:0]  seg_out
);
  p_onehot_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(dig_sel) == 1);

  p_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !mux_tick |=> $stable(dig_sel));

  p_blank_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (dig_sel != $past(dig_sel)) |-> (seg_out == '0));

  p_test_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (test_on && seg_out != '0) |-> (seg_out == '1));

  p_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_cs && !cs_q && wr_addr == 8'h04 && wr_data[5] && !test_on) |=> (seg_out == '0));
endmodule

bind blink_scan blink_scan_chk #(.DIGITS(DIGITS), .SEG_W(SEG_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .mux_tick(mux_tick), .wr_cs(wr_cs), .cs_q(cs_q),
  .wr_addr(wr_addr), .wr_data(wr_data), .test_on(test_on),
  .dig_sel(dig_sel), .seg_out(seg_out)
);

// File: tb/blink_scan_tb.sv
`timescale 1ns/1ps
module blink_scan_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mux_tick = 1'b0;
  logic wr_cs = 1'b0;
  logic [7:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [7:0] dig_sel;
  logic [7:0] seg_out;

  int total = 0;
  int bad = 0;
  int tick_mode = 0;
  bit done = 0;
  string cur_req = "R11";

  int m_p0 [8];
  int m_p1 [8];
  int m_dig, m_lim, m_pre;
  bit m_blank, m_plane, m_phase, m_en, m_fast, m_test, m_csq;

  always #5 clk = ~clk;

  blink_scan dut_i (.clk(clk), .rst_n(rst_n), .mux_tick(mux_tick), .wr_cs(wr_cs),
    .wr_addr(wr_addr), .wr_data(wr_data), .dig_sel(dig_sel), .seg_out(seg_out));

  always @(posedge clk) begin
    if (!rst_n) begin
      foreach (m_p0[i]) begin m_p0[i] = 0; m_p1[i] = 0; end
      m_dig = 0; m_lim = 7; m_pre = 0;
      m_blank = 1; m_plane = 0; m_phase = 0; m_en = 0; m_fast = 0; m_test = 0; m_csq = 0;
    end else begin
      bit fire, nen;
      fire = wr_cs && !m_csq;
      m_csq = wr_cs;
      nen = m_en;
      if (fire && wr_addr == 8'h04) nen = wr_data[3];
      if (mux_tick) begin
        if (m_blank) m_blank = 0;
        else begin
          m_blank = 1;
          m_dig = (m_dig >= m_lim) ? 0 : m_dig + 1;
          m_plane = m_en & m_phase;
        end
      end
      if (nen != m_en || !m_en) begin
        m_pre = 0; m_phase = 0;
      end else if (mux_tick) begin
        if (m_pre >= (m_fast ? 4095 : 8191)) begin m_pre = 0; m_phase = !m_phase; end
        else m_pre++;
      end
      if (fire) begin
        if (wr_addr == 8'h03) m_lim = wr_data[2:0];
        if (wr_addr == 8'h07) m_test = wr_data[0];
        if (wr_addr == 8'h04) begin
          m_en = wr_data[3]; m_fast = wr_data[2];
          if (wr_data[5]) foreach (m_p0[i]) begin m_p0[i] = 0; m_p1[i] = 0; end
        end
        if (wr_addr[7:3] == 5'b01100) m_p0[wr_addr[2:0]] = wr_data;
        if (wr_addr[7:3] == 5'b01101) m_p1[wr_addr[2:0]] = wr_data;
      end
    end
  end

  task automatic check(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      int exp_seg;
      exp_seg = m_blank ? 0 : m_test ? 255 : (m_plane ? m_p1[m_dig] : m_p0[m_dig]);
      check({cur_req, " R3 dig_sel"}, dig_sel, 1 << m_dig);
      check({cur_req, " R4 seg_out"}, seg_out, exp_seg);
    end
  end

  initial begin
    int n;
    n = 0;
    forever begin
      @(negedge clk);
      n++;
      mux_tick = (tick_mode == 1) || (tick_mode == 2 && n % 3 == 0);
    end
  end

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_addr = a; wr_data = d; wr_cs = 1'b1;
    @(negedge clk);
    wr_cs = 1'b0;
  endtask

  task automatic run(input int c);
    repeat (c) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R11 reset dig_sel", dig_sel, 8'h01);
    check("R11 reset seg_out", seg_out, 8'h00);

    cur_req = "R10 R7";
    for (int i = 0; i < 8; i++) begin
      wr(8'h60 + 8'(i), 8'(8'h11 * (i + 1)));
      wr(8'h68 + 8'(i), 8'(~(8'h11 * (i + 1))));
    end
    tick_mode = 1;
    run(40);

    cur_req = "R2";
    wr(8'h03, 8'hF2);
    run(30);
    wr(8'h03, 8'h00);
    run(12);
    wr(8'h03, 8'h05);
    tick_mode = 2;
    run(60);
    tick_mode = 1;

    cur_req = "R5";
    wr(8'h07, 8'hFF);
    run(25);
    wr(8'h07, 8'hFE);
    run(20);

    cur_req = "R1";
    @(negedge clk);
    wr_addr = 8'h07; wr_data = 8'h00; wr_cs = 1'b1;
    run(3);
    wr_data = 8'h01;
    run(5);
    wr_addr = 8'h03; wr_data = 8'h00;
    run(5);
    wr_cs = 1'b0;
    run(20);

    cur_req = "R8";
    wr(8'h03, 8'h01);
    wr(8'h04, 8'h0C);
    run(9000);
    wr(8'h04, 8'h08);
    run(17000);

    cur_req = "R9";
    wr(8'h04, 8'h00);
    run(50);
    wr(8'h04, 8'h0C);
    run(3000);
    wr(8'h04, 8'h04);
    wr(8'h04, 8'h0C);
    tick_mode = 2;
    run(13000);
    tick_mode = 1;

    cur_req = "R6";
    wr(8'h04, 8'h08);
    run(30);
    wr(8'h04, 8'h2C);
    run(40);
    check("R6 cleared seg_out", seg_out, 8'h00);
    wr(8'h60, 8'h3C);
    wr(8'h61, 8'h81);
    wr(8'h04, 8'h00);
    run(40);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #1500000;
    if (!done) begin
      done = 1;
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule